// File: doc/BRIEF.md
# I2C Target Wake-on-Match Controller

This block is the always-on front end of an I2C target. It runs from a small sampling clock that never stops, while the system and the peripheral clock sleep. It watches the bus lines and decides whether the system has to wake up. A START condition makes it ask for the peripheral clock. It holds SCL low until that clock is reported running, then lets the controller clock in the first byte. That byte carries a 7-bit address and a R/W bit, and it is compared against a primary address and a set of extra addresses, each with its own enable.

Data matching can be switched on. The first data byte after the address must then also equal a programmed pattern. When every required comparison passes, the block acknowledges the byte, raises a wake request and sets a sticky access flag. Software reads that flag to learn that the bus interface caused the wake. On any miss, the block sends no acknowledge, withdraws its clock request and falls back to idle, and the system is never woken. A STOP or a repeated START before the match completes also sends it back to idle. If the clock acknowledge does not arrive in time, the block gives up.

The controller states are IDLE, STRETCH, ADDR, ADDR_ACK, DATA, DATA_ACK and WAKE. The transitions are as follows.
- IDLE goes to STRETCH on START.
- STRETCH goes to ADDR on clk_ack, and to IDLE on timeout.
- ADDR goes to ADDR_ACK on an address hit and to IDLE on a miss. It also returns to IDLE on STOP or START.
- ADDR_ACK goes to DATA when data matching is in effect, and to WAKE otherwise.
- DATA goes to DATA_ACK on a pattern hit and to IDLE on a miss.
- DATA_ACK goes to WAKE.
- WAKE goes to IDLE on STOP.
- In the ACK states, a STOP or START also returns the block to IDLE.

Top module: `i2c_wake_matcher`

## Requirements
- R1: A START (SDA falling while SCL is high, seen through a two-flop synchronizer) takes IDLE to STRETCH. clk_req is high in every state except IDLE.
- R2: In STRETCH, scl_hold is high in every cycle in which clk_ack is low. It is low in the first cycle clk_ack is high, and the block then moves to ADDR.
- R3: If clk_ack stays low for TIMEOUT_CYCLES consecutive cycles in STRETCH, the block returns to IDLE, drops clk_req and does not wake.
- R4: The address byte is shifted in MSB first on SCL rising edges. Byte bits [7:1] are the address and bit 0 (R/W) is ignored. The address hits if it equals own_addr, or equals alt_addr[7*i+6:7*i] for any i whose alt_en[i] is 1.
- R5: On an address hit, sda_hold is raised after the SCL fall that ends the eighth bit. It is dropped after the SCL fall that ends the ninth clock.
- R6: On an address miss, the block returns to IDLE at the SCL fall that ends the eighth bit, with no acknowledge and no wake.
- R7: When data matching is in effect, the first data byte must equal data_pattern. A hit is acknowledged like R5 and a miss returns to IDLE without acknowledge or wake.
- R8: Data matching is in effect only when data_match_en is 1 and sys_active is 0. Otherwise an address hit alone completes the match.
- R9: A complete match enters WAKE at the end of the final acknowledge clock. wake and clk_req stay high until a STOP returns the block to IDLE.
- R10: acc_flag is set on entry to WAKE and holds until a cycle with acc_clr high clears it. A clear in the same cycle as a set wins.
- R11: A STOP or repeated START in ADDR, ADDR_ACK, DATA or DATA_ACK returns the block to IDLE without wake.
- R12: During reset all outputs are low and the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| own_addr | input | ADDR_W | Primary target address |
| alt_addr | input | NUM_ALT*ADDR_W | Extra addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| alt_en | input | NUM_ALT | Per-entry enable for the extra addresses |
| data_match_en | input | 1 | Require a first-data-byte match |
| data_pattern | input | ADDR_W+1 | Pattern for the first data byte |
| sys_active | input | 1 | System already running; disables data matching |
| clk_ack | input | 1 | Peripheral clock reported running |
| acc_clr | input | 1 | One-cycle clear of acc_flag |
| clk_req | output | 1 | Peripheral clock request |
| scl_hold | output | 1 | Pull SCL low (stretch) |
| sda_hold | output | 1 | Pull SDA low (acknowledge) |
| wake | output | 1 | System wake request |
| acc_flag | output | 1 | Sticky access indication |

## Verification
The access flag's set on entry to WAKE and a software clear can land in the same cycle, and the clear must win. The bench provokes this by holding acc_clr high through a whole matching transaction, so the set edge coincides with a clear. It judges the result by wake rising while acc_flag stays low after clear is released. Abort by STOP or repeated START, which can meet a bit-count boundary, is provoked in the middle of an address byte. A behavioural model is compared against the outputs on every clock in all of these cases.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRETCH,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_WAKE
    } wake_state_t;
endpackage

// File: rtl/wk_bus_sampler.sv
module wk_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic scl_now, scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_raw};
        end
    end

    assign scl_now  = scl_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_lvl  = sda_pipe[STAGES-1];
    assign sda_prev = sda_pipe[STAGES];

    always_comb begin
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_now & scl_prev & ~sda_lvl & sda_prev;
        stop_det  = scl_now & scl_prev & sda_lvl & ~sda_prev;
    end
endmodule

// File: rtl/wk_byte_match.sv
module wk_byte_match #(
    parameter int ADDR_W  = 7,
    parameter int NUM_ALT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic                      bit_in,
    input  logic [ADDR_W-1:0]         own_addr,
    input  logic [NUM_ALT*ADDR_W-1:0] alt_addr,
    input  logic [NUM_ALT-1:0]        alt_en,
    input  logic [ADDR_W:0]           pattern,
    output logic                      addr_hit,
    output logic                      data_hit
);
    localparam int BYTE_W = ADDR_W + 1;

    logic [BYTE_W-1:0]  shreg;
    logic [NUM_ALT-1:0] alt_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (shift_en)
            shreg <= {shreg[BYTE_W-2:0], bit_in};
    end

    for (genvar g = 0; g < NUM_ALT; g++) begin : g_alt
        assign alt_hit[g] = alt_en[g] &&
                            (shreg[BYTE_W-1:1] == alt_addr[g*ADDR_W +: ADDR_W]);
    end

    assign addr_hit = (shreg[BYTE_W-1:1] == own_addr) || (|alt_hit);
    assign data_hit = (shreg == pattern);
endmodule

// File: rtl/i2c_wake_matcher.sv
module i2c_wake_matcher
    import wake_pkg::*;
#(
    parameter int ADDR_W         = 7,
    parameter int NUM_ALT        = 3,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    input  logic [ADDR_W-1:0]         own_addr,
    input  logic [NUM_ALT*ADDR_W-1:0] alt_addr,
    input  logic [NUM_ALT-1:0]        alt_en,
    input  logic                      data_match_en,
    input  logic [ADDR_W:0]           data_pattern,
    input  logic                      sys_active,
    input  logic                      clk_ack,
    input  logic                      acc_clr,
    output logic                      clk_req,
    output logic                      scl_hold,
    output logic                      sda_hold,
    output logic                      wake,
    output logic                      acc_flag
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int TMO_W  = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    wake_state_t      state, nstate;
    logic [CNT_W-1:0] bit_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             ack_clk_seen;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic addr_hit, data_hit;
    logic abort, byte_done, tmo_hit, data_chk, in_byte, in_ack, set_acc;

    wk_bus_sampler #(.STAGES(2)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    wk_byte_match #(.ADDR_W(ADDR_W), .NUM_ALT(NUM_ALT)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(in_byte && scl_rise),
        .bit_in  (sda_lvl),
        .own_addr(own_addr),
        .alt_addr(alt_addr),
        .alt_en  (alt_en),
        .pattern (data_pattern),
        .addr_hit(addr_hit),
        .data_hit(data_hit)
    );

    always_comb begin
        abort     = start_det | stop_det;
        byte_done = (bit_cnt == CNT_FULL);
        tmo_hit   = (tmo_cnt == TMO_LAST);
        data_chk  = data_match_en & ~sys_active;
        in_byte   = (state == ST_ADDR) || (state == ST_DATA);
        in_ack    = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
        set_acc   = (nstate == ST_WAKE) && (state != ST_WAKE);
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (start_det) nstate = ST_STRETCH;
            ST_STRETCH: begin
                if (clk_ack)      nstate = ST_ADDR;
                else if (tmo_hit) nstate = ST_IDLE;
            end
            ST_ADDR: begin
                if (abort)                      nstate = ST_IDLE;
                else if (scl_fall && byte_done) nstate = addr_hit ? ST_ADDR_ACK : ST_IDLE;
            end
            ST_ADDR_ACK: begin
                if (abort)                         nstate = ST_IDLE;
                else if (scl_fall && ack_clk_seen) nstate = data_chk ? ST_DATA : ST_WAKE;
            end
            ST_DATA: begin
                if (abort)                      nstate = ST_IDLE;
                else if (scl_fall && byte_done) nstate = data_hit ? ST_DATA_ACK : ST_IDLE;
            end
            ST_DATA_ACK: begin
                if (abort)                         nstate = ST_IDLE;
                else if (scl_fall && ack_clk_seen) nstate = ST_WAKE;
            end
            ST_WAKE:     if (stop_det) nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // state and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bit_cnt      <= '0;
            tmo_cnt      <= '0;
            ack_clk_seen <= 1'b0;
            acc_flag     <= 1'b0;
        end else begin
            state <= nstate;

            if (!in_byte)
                bit_cnt <= '0;
            else if (scl_rise)
                bit_cnt <= bit_cnt + 1'b1;

            if (state == ST_STRETCH)
                tmo_cnt <= tmo_cnt + 1'b1;
            else
                tmo_cnt <= '0;

            if (!in_ack)
                ack_clk_seen <= 1'b0;
            else if (scl_rise)
                ack_clk_seen <= 1'b1;

            if (acc_clr)
                acc_flag <= 1'b0;
            else if (set_acc)
                acc_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        clk_req  = (state != ST_IDLE);
        scl_hold = (state == ST_STRETCH) && !clk_ack;
        sda_hold = in_ack;
        wake     = (state == ST_WAKE);
    end

    p_req_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_det) |=> clk_req);

    p_hold_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (clk_req && !clk_ack));

    p_stretch_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && clk_ack) |=> (state == ST_ADDR && !scl_hold));

    p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && !clk_ack && tmo_cnt == TMO_LAST) |=> !clk_req);

    p_ack_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_hold) |-> $past(scl_fall));

    p_wake_keeps_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> clk_req);

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> !acc_flag);

    p_flag_with_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_flag) |-> (wake && $past(!acc_clr)));

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_byte && stop_det) |=> (state == ST_IDLE));
endmodule

// File: tb/i2c_wake_matcher_test.sv
module i2c_wake_matcher_test;
    localparam int ADDR_W = 7;
    localparam int NUM_ALT = 3;
    localparam int TMO = 64;
    localparam int H = 8;
    localparam int ACK_LAT = 5;
    localparam int P_IDLE = 0, P_STR = 1, P_ADDR = 2, P_AACK = 3, P_DATA = 4, P_DACK = 5, P_WAKE = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, scl_m, sda_m, clk_ack, acc_clr, ack_on;
    logic [ADDR_W-1:0] own_addr;
    logic [NUM_ALT*ADDR_W-1:0] alt_addr;
    logic [NUM_ALT-1:0] alt_en;
    logic data_match_en, sys_active;
    logic [ADDR_W:0] data_pattern;
    logic clk_req, scl_hold, sda_hold, wake, acc_flag;
    logic scl_bus, sda_bus;

    assign scl_bus = scl_m & ~scl_hold;
    assign sda_bus = sda_m & ~sda_hold;

    i2c_wake_matcher #(.ADDR_W(ADDR_W), .NUM_ALT(NUM_ALT), .TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .own_addr(own_addr), .alt_addr(alt_addr), .alt_en(alt_en),
        .data_match_en(data_match_en), .data_pattern(data_pattern),
        .sys_active(sys_active), .clk_ack(clk_ack), .acc_clr(acc_clr),
        .clk_req(clk_req), .scl_hold(scl_hold), .sda_hold(sda_hold),
        .wake(wake), .acc_flag(acc_flag)
    );

    int vectors = 0;
    int errors = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // peripheral clock model: ack follows request after a latency
    int ack_cnt = 0;
    always @(posedge clk) begin
        #2;
        if (!ack_on || !clk_req) begin
            ack_cnt = 0;
            clk_ack = 1'b0;
        end else if (ack_cnt >= ACK_LAT) begin
            clk_ack = 1'b1;
        end else begin
            ack_cnt++;
        end
    end

    // behavioural reference model
    int m_phase = P_IDLE, m_cnt = 0, m_byte = 0, m_seen = 0, m_tmo = 0, m_acc = 0, m_live = 0;
    int hs_scl[$] = '{1, 1, 1};
    int hs_sda[$] = '{1, 1, 1};
    logic sn_rst = 1'b0, sn_scl = 1'b1, sn_sda = 1'b1, sn_ack = 1'b0, sn_clr = 1'b0;

    function automatic int addr_ok(input int b);
        int a;
        a = (b >> 1) & 127;
        if (a == int'(own_addr)) return 1;
        for (int i = 0; i < NUM_ALT; i++)
            if (alt_en[i] && a == int'(alt_addr[i*ADDR_W +: ADDR_W])) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        int cs, ps, cd, pd, entering;
        bit rise, fall, st, sp;
        if (!sn_rst) begin
            m_phase = P_IDLE; m_cnt = 0; m_byte = 0; m_seen = 0; m_tmo = 0; m_acc = 0; m_live = 0;
            hs_scl = '{1, 1, 1};
            hs_sda = '{1, 1, 1};
        end else begin
            cs = hs_scl[1]; ps = hs_scl[2]; cd = hs_sda[1]; pd = hs_sda[2];
            rise = (cs == 1 && ps == 0);
            fall = (cs == 0 && ps == 1);
            st = (cs == 1 && ps == 1 && cd == 0 && pd == 1);
            sp = (cs == 1 && ps == 1 && cd == 1 && pd == 0);
            entering = 0;
            case (m_phase)
                P_IDLE: if (st) begin m_phase = P_STR; m_tmo = 0; end
                P_STR: begin
                    if (sn_ack) begin m_phase = P_ADDR; m_cnt = 0; m_byte = 0; end
                    else if (m_tmo == TMO - 1) m_phase = P_IDLE;
                    else m_tmo++;
                end
                P_ADDR, P_DATA: begin
                    if (st || sp) m_phase = P_IDLE;
                    else if (rise) begin m_byte = ((m_byte << 1) | cd) & 255; m_cnt++; end
                    else if (fall && m_cnt == 8) begin
                        if (m_phase == P_ADDR) m_phase = addr_ok(m_byte) ? P_AACK : P_IDLE;
                        else m_phase = (m_byte == int'(data_pattern)) ? P_DACK : P_IDLE;
                        m_seen = 0;
                    end
                end
                P_AACK, P_DACK: begin
                    if (st || sp) m_phase = P_IDLE;
                    else if (rise) m_seen = 1;
                    else if (fall && m_seen == 1) begin
                        if (m_phase == P_AACK && data_match_en && !sys_active) begin
                            m_phase = P_DATA; m_cnt = 0; m_byte = 0;
                        end else begin
                            m_phase = P_WAKE; entering = 1;
                        end
                    end
                end
                P_WAKE: if (sp) m_phase = P_IDLE;
                default: m_phase = P_IDLE;
            endcase
            if (sn_clr) m_acc = 0;
            else if (entering == 1) m_acc = 1;
            hs_scl.push_front(int'(sn_scl)); void'(hs_scl.pop_back());
            hs_sda.push_front(int'(sn_sda)); void'(hs_sda.pop_back());
            m_live = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live == 1) begin
            check("R1", "clk_req", int'(clk_req), int'(m_phase != P_IDLE));
            check("R2", "scl_hold", int'(scl_hold), int'(m_phase == P_STR && !clk_ack));
            check("R5", "sda_hold", int'(sda_hold), int'(m_phase == P_AACK || m_phase == P_DACK));
            check("R9", "wake", int'(wake), int'(m_phase == P_WAKE));
            check("R10", "acc_flag", int'(acc_flag), m_acc);
        end
        sn_rst = rst_n; sn_scl = scl_bus; sn_sda = sda_bus; sn_ack = clk_ack; sn_clr = acc_clr;
    end

    // bus controller tasks
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic raise_scl();
        scl_m = 1'b1;
        tick(1);
        while (!scl_bus) tick(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        raise_scl(); tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(H);
        raise_scl(); tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic ack_slot(output int got);
        sda_m = 1'b1; tick(H);
        raise_scl(); tick(H / 2);
        got = int'(!sda_bus);
        tick(H / 2);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic xact(input logic [7:0] ab, input int has_data, input logic [7:0] db,
                        output int a_ack, output int d_ack, output int wk);
        bus_start();
        send_byte(ab);
        ack_slot(a_ack);
        d_ack = 0;
        if (has_data == 1) begin
            send_byte(db);
            ack_slot(d_ack);
        end
        wk = int'(wake);
        bus_stop();
        tick(4);
    endtask

    task automatic clear_flag();
        acc_clr = 1'b1; tick(1);
        acc_clr = 1'b0; tick(1);
    endtask

    task automatic run_all();
        int a, d, w;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; acc_clr = 1'b0; ack_on = 1'b1;
        own_addr = 7'h2A;
        alt_addr = {7'h55, 7'h44, 7'h33};
        alt_en = 3'b101;
        data_match_en = 1'b0; sys_active = 1'b0; data_pattern = 8'hA5;
        tick(4);
        check("R12", "reset clk_req", int'(clk_req), 0);
        check("R12", "reset hold lines", int'(scl_hold | sda_hold), 0);
        check("R12", "reset wake/flag", int'(wake | acc_flag), 0);
        rst_n = 1'b1; tick(3);

        // R4/R5/R9/R10: primary address, write
        xact(8'h54, 0, 8'h00, a, d, w);
        check("R5", "primary address acked", a, 1);
        check("R9", "wake on primary", w, 1);
        check("R10", "flag set after wake", int'(acc_flag), 1);
        check("R9", "wake dropped by STOP", int'(wake), 0);
        clear_flag();
        check("R10", "flag cleared", int'(acc_flag), 0);

        // R4: R/W bit ignored
        xact(8'h55, 0, 8'h00, a, d, w);
        check("R4", "read bit ignored", w, 1);
        clear_flag();

        // R6: miss
        xact(8'h40, 0, 8'h00, a, d, w);
        check("R6", "miss not acked", a, 0);
        check("R6", "miss no wake", w, 0);
        check("R6", "miss clk_req dropped", int'(clk_req), 0);

        // R4: extra addresses
        xact({7'h33, 1'b0}, 0, 8'h00, a, d, w);
        check("R4", "alt0 enabled match", w, 1);
        clear_flag();
        xact({7'h44, 1'b0}, 0, 8'h00, a, d, w);
        check("R4", "alt1 disabled miss", a, 0);
        xact({7'h55, 1'b1}, 0, 8'h00, a, d, w);
        check("R4", "alt2 enabled match", w, 1);
        clear_flag();

        // R7: data matching
        data_match_en = 1'b1;
        xact(8'h54, 1, 8'hA5, a, d, w);
        check("R7", "data hit acked", d, 1);
        check("R7", "data hit wakes", w, 1);
        clear_flag();
        xact(8'h54, 1, 8'h5A, a, d, w);
        check("R7", "address acked before data miss", a, 1);
        check("R7", "data miss not acked", d, 0);
        check("R7", "data miss no wake", w, 0);
        check("R7", "data miss no flag", int'(acc_flag), 0);

        // R8: system active overrides data matching
        sys_active = 1'b1;
        xact(8'h54, 1, 8'h5A, a, d, w);
        check("R8", "active wakes on address only", w, 1);
        check("R8", "data byte not acked", d, 0);
        clear_flag();
        sys_active = 1'b0; data_match_en = 1'b0;

        // R1/R2/R3: stretch without clock acknowledge, then timeout
        ack_on = 1'b0;
        bus_start();
        check("R1", "request after START", int'(clk_req), 1);
        check("R2", "SCL held without ack", int'(scl_hold), 1);
        tick(TMO + 10);
        check("R3", "timeout drops request", int'(clk_req), 0);
        check("R3", "timeout releases SCL", int'(scl_hold), 0);
        check("R3", "timeout no wake", int'(wake), 0);
        bus_stop(); tick(4);
        ack_on = 1'b1;

        // R11: STOP inside address byte
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop(); tick(4);
        check("R11", "STOP mid-address aborts", int'(clk_req), 0);

        // R11: repeated START inside address byte
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        sda_m = 1'b1; tick(H);
        raise_scl(); tick(H);
        sda_m = 1'b0; tick(H);
        check("R11", "repeated START aborts", int'(clk_req), 0);
        scl_m = 1'b0; tick(H);
        bus_stop(); tick(4);
        check("R11", "no wake after abort", int'(wake), 0);

        // R10: clear held across the set cycle wins
        acc_clr = 1'b1;
        xact(8'h54, 0, 8'h00, a, d, w);
        check("R10", "wake while clear held", w, 1);
        acc_clr = 1'b0; tick(2);
        check("R10", "clear beat coincident set", int'(acc_flag), 0);
        tick(4);
    endtask

    initial begin
        clk_ack = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule